// File: doc/BRIEF.md
# Six-Digit Time-of-Day Counter

This block keeps the time of day for a six-digit clock display. A tick from the mains-frequency detector arrives as a one-cycle enable pulse at 60 Hz. A prescaler turns every sixtieth tick into a seconds step. Seconds, minutes and hours are each held as a pair of BCD digits, tens and units, and each digit can go straight to its own seven-segment decoder. When the seconds pass 59 they step the minutes. When the minutes pass 59 they step the hours. The hours wrap after 23, or after 11 when the build parameter `TWELVE_HOUR` is 1.

Everything runs on one system clock. There are no derived clocks. A small controller has two states. In `RUN`, ticks advance the counters. In `SET`, the seconds and the prescaler are held at zero, and separate set pulses advance the minutes or the hours by one step each, with no carry between them. Transitions: `RUN -> SET` when `set_mode` is high at a clock edge; `SET -> RUN` when it is low at a clock edge; each state holds otherwise. A synchronous reset forces `RUN` and 00:00:00.

Top module: `clock_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all six digits become 0 and the controller enters `RUN`.
- R2: In `RUN`, the seconds advance by one on the edge that samples the 60th `tick` since the last second step or since leaving `SET`. Cycles with `tick` low change nothing.
- R3: Seconds go 00 to 59 in BCD. A units digit of 9 rolls to 0 and raises the tens digit by one. The next step after 59 gives 00.
- R4: The seconds step from 59 to 00 advances the minutes by one on the same edge. Minutes run 00 to 59 and wrap to 00.
- R5: The minutes step from 59 to 00, with the seconds at 59 to 00, advances the hours on the same edge. Hours wrap from 23 to 00 when `TWELVE_HOUR` is 0, and from 11 to 00 when it is 1.
- R6: The hour digits never show a value at or above 24, or at or above 12 in twelve-hour mode.
- R7: The controller registers `set_mode` with a one-edge delay. Every edge while the controller is in `SET` clears the seconds and the prescaler, and `tick` has no effect.
- R8: In `SET`, a `set_min` pulse advances the minutes by one and wraps 59 to 00 without changing the hours. In `RUN`, `set_min` is ignored.
- R9: In `SET`, a `set_hour` pulse advances the hours by one and wraps at the hour limit without changing the minutes. In `RUN`, `set_hour` is ignored.
- R10: After `SET -> RUN`, counting restarts from a cleared prescaler. The first seconds step needs a full 60 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse at the mains rate (60 per second) |
| set_mode | input | 1 | Hold high to set the time |
| set_min | input | 1 | Single-cycle minute advance in set mode |
| set_hour | input | 1 | Single-cycle hour advance in set mode |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_units | output | 4 | Seconds units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_units | output | 4 | Hours units digit, BCD |

## Verification
The bench targets five boundaries:

- Exactly 60 ticks per second. An off-by-one prescaler would step after 59 or 61 ticks.
- The units-to-tens BCD carry. A binary counter would show 0A after 09.
- The joint 23:59:59 to 00:00:00 rollover. A design that compares only one nibble would pass through 24 or stop at 20.
- Set pulses at 59 and at 23. A design with a leaking carry would bump the hour when the minutes are set past 59.
- Ticks arriving during set mode, which must be dropped.

A behavioural model runs beside the design and is compared on every cycle. It catches any drift between these points.

// File: rtl/clock_chain_pkg.sv
package clock_chain_pkg;

    typedef enum logic {
        RUN = 1'b0,
        SET = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd2_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic pulse_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign pulse_o = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter
    import clock_chain_pkg::*;
#(
    parameter int TERM_TENS  = 5,
    parameter int TERM_UNITS = 9
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  inc,
    output bcd2_t val_o,
    output logic  wrap_o
);
    localparam logic [3:0] TT = 4'(TERM_TENS);
    localparam logic [3:0] TU = 4'(TERM_UNITS);

    bcd2_t val_q;
    logic  at_term;

    // terminal is judged on both digits at once
    assign at_term = (val_q.tens == TT) && (val_q.units == TU);
    assign wrap_o  = inc && at_term;
    assign val_o   = val_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val_q <= '0;
        end else if (inc) begin
            if (at_term) begin
                val_q <= '0;
            end else if (val_q.units == 4'd9) begin
                val_q.units <= 4'd0;
                val_q.tens  <= val_q.tens + 4'd1;
            end else begin
                val_q.units <= val_q.units + 4'd1;
            end
        end
    end
endmodule

// File: rtl/clock_chain.sv
module clock_chain
    import clock_chain_pkg::*;
#(
    parameter int TICKS_PER_SEC = 60,
    parameter bit TWELVE_HOUR   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       set_mode,
    input  logic       set_min,
    input  logic       set_hour,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_units
);
    localparam int HR_TERM_T = TWELVE_HOUR ? 1 : 2;
    localparam int HR_TERM_U = TWELVE_HOUR ? 1 : 3;

    ctl_state_t state_q, state_d;
    logic  pre_tick, hold_clr, min_inc, hr_inc;
    logic  sec_step, sec_wrap, min_wrap, hr_wrap;
    bcd2_t sec_v, min_v, hr_v;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and per-state controls
    always_comb begin
        state_d  = state_q;
        pre_tick = 1'b0;
        hold_clr = 1'b0;
        min_inc  = 1'b0;
        hr_inc   = 1'b0;
        unique case (state_q)
            RUN: begin
                if (set_mode) state_d = SET;
                pre_tick = tick;
                min_inc  = sec_wrap;
                hr_inc   = min_wrap;
            end
            SET: begin
                if (!set_mode) state_d = RUN;
                hold_clr = 1'b1;
                min_inc  = set_min;
                hr_inc   = set_hour;
            end
            default: state_d = RUN;
        endcase
    end

    tick_prescaler #(.DIV(TICKS_PER_SEC)) u_pre (
        .clk(clk), .rst(rst), .clr(hold_clr), .tick(pre_tick), .pulse_o(sec_step)
    );

    bcd_pair_counter #(.TERM_TENS(5), .TERM_UNITS(9)) u_sec (
        .clk(clk), .rst(rst), .clr(hold_clr), .inc(sec_step),
        .val_o(sec_v), .wrap_o(sec_wrap)
    );

    bcd_pair_counter #(.TERM_TENS(5), .TERM_UNITS(9)) u_min (
        .clk(clk), .rst(rst), .clr(1'b0), .inc(min_inc),
        .val_o(min_v), .wrap_o(min_wrap)
    );

    generate
        if (TWELVE_HOUR) begin : g_h12
            bcd_pair_counter #(.TERM_TENS(HR_TERM_T), .TERM_UNITS(HR_TERM_U)) u_hr (
                .clk(clk), .rst(rst), .clr(1'b0), .inc(hr_inc),
                .val_o(hr_v), .wrap_o(hr_wrap)
            );
        end else begin : g_h24
            bcd_pair_counter #(.TERM_TENS(HR_TERM_T), .TERM_UNITS(HR_TERM_U)) u_hr (
                .clk(clk), .rst(rst), .clr(1'b0), .inc(hr_inc),
                .val_o(hr_v), .wrap_o(hr_wrap)
            );
        end
    endgenerate

    // hour wrap has no downstream stage
    logic unused_hr_wrap;
    assign unused_hr_wrap = hr_wrap;

    assign sec_tens  = sec_v.tens;
    assign sec_units = sec_v.units;
    assign min_tens  = min_v.tens;
    assign min_units = min_v.units;
    assign hr_tens   = hr_v.tens;
    assign hr_units  = hr_v.units;
endmodule

// File: rtl/clock_chain_chk.sv
module clock_chain_chk #(
    parameter bit TWELVE_HOUR = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       set_mode,
    input logic       set_min,
    input logic       set_hour,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_units,
    input logic [3:0] min_tens,
    input logic [3:0] min_units,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_units
);
    localparam int HR_LIMIT = TWELVE_HOUR ? 12 : 24;

    p_sec_bcd_r3: assert property (@(posedge clk) disable iff (rst)
        (sec_units <= 4'd9) && (sec_tens <= 4'd5));

    p_min_bcd_r4: assert property (@(posedge clk) disable iff (rst)
        (min_units <= 4'd9) && (min_tens <= 4'd5));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (hr_units <= 4'd9) && ((int'(hr_tens) * 10 + int'(hr_units)) < HR_LIMIT));

    p_set_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(set_mode, 2) && $past(set_mode) && !$past(rst) && !$past(rst, 2))
        |-> (sec_tens == 4'd0 && sec_units == 4'd0));

    p_set_min_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(set_mode, 2) && $past(set_mode) && !$past(set_hour) && !$past(rst) && !$past(rst, 2))
        |-> ($stable(hr_tens) && $stable(hr_units)));

    p_set_hour_only_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(set_mode, 2) && $past(set_mode) && !$past(set_min) && !$past(rst) && !$past(rst, 2))
        |-> ($stable(min_tens) && $stable(min_units)));
endmodule

bind clock_chain clock_chain_chk #(.TWELVE_HOUR(TWELVE_HOUR)) u_chk (
    .clk(clk), .rst(rst), .set_mode(set_mode), .set_min(set_min), .set_hour(set_hour),
    .sec_tens(sec_tens), .sec_units(sec_units), .min_tens(min_tens), .min_units(min_units),
    .hr_tens(hr_tens), .hr_units(hr_units)
);

// File: tb/clock_chain_bench.sv
module clock_chain_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, set_mode = 1'b0, set_min = 1'b0, set_hour = 1'b0;
    logic [3:0] sec_tens, sec_units, min_tens, min_units, hr_tens, hr_units;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // behavioural reference
    int m_pre = 0, m_s = 0, m_m = 0, m_h = 0;
    bit m_set = 1'b0;

    always #10 clk = ~clk;

    clock_chain u_clock_chain (
        .clk(clk), .rst(rst), .tick(tick), .set_mode(set_mode),
        .set_min(set_min), .set_hour(set_hour),
        .sec_tens(sec_tens), .sec_units(sec_units),
        .min_tens(min_tens), .min_units(min_units),
        .hr_tens(hr_tens), .hr_units(hr_units)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pre = 0; m_s = 0; m_m = 0; m_h = 0; m_set = 1'b0;
        end else begin
            if (m_set) begin
                m_pre = 0; m_s = 0;
                if (set_min)  m_m = (m_m + 1) % 60;
                if (set_hour) m_h = (m_h + 1) % 24;
            end else if (tick) begin
                if (m_pre == 59) begin
                    m_pre = 0;
                    m_s++;
                    if (m_s == 60) begin
                        m_s = 0; m_m++;
                        if (m_m == 60) begin
                            m_m = 0; m_h = (m_h + 1) % 24;
                        end
                    end
                end else begin
                    m_pre++;
                end
            end
            m_set = set_mode;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (sec_tens != 4'(m_s / 10) || sec_units != 4'(m_s % 10) ||
                min_tens != 4'(m_m / 10) || min_units != 4'(m_m % 10) ||
                hr_tens  != 4'(m_h / 10) || hr_units  != 4'(m_h % 10)) begin
                fails++;
                $display("FAIL R3/R4/R5 model compare: got %0d%0d:%0d%0d:%0d%0d expected %0d:%0d:%0d",
                         hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units, m_h, m_m, m_s);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drive(input bit tk, input bit sm, input bit smin, input bit shr);
        tick = tk; set_mode = sm; set_min = smin; set_hour = shr;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 1'b0);
        tick = 1'b0;
    endtask

    task automatic check_time(input string req, input int h, input int m, input int s);
        int got_h, got_m, got_s;
        got_h = int'(hr_tens) * 10 + int'(hr_units);
        got_m = int'(min_tens) * 10 + int'(min_units);
        got_s = int'(sec_tens) * 10 + int'(sec_units);
        checks++;
        if (got_h != h || got_m != m || got_s != s || sec_units > 9 || min_units > 9 || hr_units > 9) begin
            fails++;
            $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d expected %0d:%0d:%0d", req,
                     hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units, h, m, s);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_time("R1 reset", 0, 0, 0);

        // R2 prescaler
        ticks(59);
        check_time("R2 59 ticks", 0, 0, 0);
        ticks(1);
        check_time("R2 60 ticks", 0, 0, 1);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
        check_time("R2 idle", 0, 0, 1);

        // R3 BCD carry and wrap
        ticks(60 * 9);
        check_time("R3 units to tens", 0, 0, 10);
        ticks(60 * 49);
        check_time("R3 at 59", 0, 0, 59);
        ticks(60);
        check_time("R4 minute carry", 0, 1, 0);

        // R8/R9 ignored in run
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        check_time("R8 R9 set pulses ignored in run", 0, 1, 0);

        // R7 set mode holds seconds, drops ticks
        ticks(30);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 70; i++) drive(1'b1, 1'b1, 1'b0, 1'b0);
        check_time("R7 set hold", 0, 1, 0);

        // R8 minutes set
        for (int i = 0; i < 58; i++) drive(1'b0, 1'b1, 1'b1, 1'b0);
        check_time("R8 set to 59", 0, 59, 0);
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        check_time("R8 wrap no carry", 0, 0, 0);
        for (int i = 0; i < 59; i++) drive(1'b0, 1'b1, 1'b1, 1'b0);

        // R9 hours set
        for (int i = 0; i < 23; i++) drive(1'b0, 1'b1, 1'b0, 1'b1);
        check_time("R9 set to 23", 23, 59, 0);
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        check_time("R9 wrap", 0, 59, 0);
        for (int i = 0; i < 23; i++) drive(1'b0, 1'b1, 1'b0, 1'b1);

        // R10 leave set, full second needed
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        ticks(59);
        check_time("R10 restart 59", 23, 59, 0);
        ticks(1);
        check_time("R10 restart 60", 23, 59, 1);

        // R5 day rollover (R6 watched by checker)
        ticks(60 * 58);
        check_time("R5 at 23:59:59", 23, 59, 59);
        ticks(60);
        check_time("R5 day wrap", 0, 0, 0);

        // R1 reset mid-run
        ticks(120);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_time("R1 reset mid-run", 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule